// File: doc/BRIEF.md
# GPIO Input Debounce Filter

This block sits between a bank of asynchronous GPIO inputs and the logic that detects pin interrupts. Each input first passes through a synchronizer. A single prescale counter divides the clock by a programmable amount and produces a sample tick, and every filtered pin uses that same tick. A pin whose debounce enable is set changes its output only after two consecutive ticks have sampled the same level. A pin whose enable is clear passes its synchronized value straight through.

Software programs the per-pin enable mask and the shared divisor through a 32-bit write port with a combinational read-back. Writing the divisor restarts the prescaler at once, so the new sample rate applies from the next cycle. While a pin is disabled, its filter state follows the synchronized input. Turning debounce on therefore leaves the output unchanged at that moment.

Top module: `gpio_debounce_top`

## Requirements
- R1: After reset, every enable bit reads 0, the divisor reads 0, the filter state is 0 and `tick_o` is 1.
- R2: The enable mask is stored at address 0x40, in bits [NUM_PINS-1:0]. The divisor is stored at address 0x44, in bits [DIV_W-1:0]. Read-back bits above each field read 0. Writes to any other address change neither register, and reads from any other address return 0.
- R3: With a divisor D of 2 or more, `tick_o` is high for one cycle in every D cycles. A divisor of 0 or 1 makes `tick_o` high on every cycle.
- R4: A divisor write reloads the prescaler from the written value. `tick_o` is low in the first D-1 cycles after the clock edge that captures the write, and high in the D-th cycle.
- R5: An enabled pin's output changes only on a tick where the synchronized input equals the value sampled on the previous tick. The output then takes that value.
- R6: On an enabled pin, a level that lasts fewer than D cycles never reaches the output.
- R7: On a disabled pin, the output equals the input delayed by exactly SYNC_STAGES clock edges.
- R8: In the cycle after a pin's enable is set, the pin's output keeps the value it had before. This holds because a disabled pin's filter state tracks its synchronized input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 8 | Register byte address |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_rdata_o | output | 32 | Read data for `cfg_addr_i` (combinational) |
| pin_i | input | NUM_PINS | Asynchronous GPIO inputs |
| pin_o | output | NUM_PINS | Filtered or synchronized pins, toward interrupt detection |
| tick_o | output | 1 | Shared sample tick |

## Verification
The bench uses NUM_PINS=8, DIV_W=24 and SYNC_STAGES=2, and mostly sets divisors between 0 and 5. These short periods let a few dozen cycles cover stable levels, glitches shorter than one tick period and the exact first tick after a reload. A divisor of 1000 keeps ticks away, which shows that an enabled pin holds its value when it is switched on. Writing all ones to the divisor and enable registers exercises field masking at the full 24-bit width.

// File: rtl/gpio_debounce_pkg.sv
package gpio_debounce_pkg;
  localparam int unsigned CFG_AW = 8;
  localparam int unsigned CFG_DW = 32;
  localparam logic [CFG_AW-1:0] ADDR_DBN_EN  = 8'h40;
  localparam logic [CFG_AW-1:0] ADDR_DBN_DIV = 8'h44;
endpackage

// File: rtl/dbn_regs.sv
module dbn_regs
  import gpio_debounce_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned DIV_W    = 24
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [CFG_AW-1:0]   addr_i,
  input  logic [CFG_DW-1:0]   wdata_i,
  output logic [CFG_DW-1:0]   rdata_o,
  output logic [NUM_PINS-1:0] en_o,
  output logic [DIV_W-1:0]    div_o,
  output logic                load_o,
  output logic [DIV_W-1:0]    load_val_o
);
  logic [NUM_PINS-1:0] en_q;
  logic [DIV_W-1:0]    div_q;
  logic                hit_en, hit_div;
  logic                unused_wdata;

  assign hit_en       = (addr_i == ADDR_DBN_EN);
  assign hit_div      = (addr_i == ADDR_DBN_DIV);
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      div_q <= '0;
    end else if (we_i) begin
      if (hit_en)  en_q  <= wdata_i[NUM_PINS-1:0];
      if (hit_div) div_q <= wdata_i[DIV_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit_en)       rdata_o[NUM_PINS-1:0] = en_q;
    else if (hit_div) rdata_o[DIV_W-1:0]    = div_q;
  end

  assign en_o       = en_q;
  assign div_o      = div_q;
  assign load_o     = we_i & hit_div;
  assign load_val_o = wdata_i[DIV_W-1:0];

  assert_ignore_other_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !hit_en && !hit_div) |=> ($stable(en_q) && $stable(div_q)));
endmodule

// File: rtl/dbn_prescaler.sv
module dbn_prescaler #(
  parameter int unsigned DIV_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             load_i,
  input  logic [DIV_W-1:0] load_val_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  // divisor 0 behaves as 1
  function automatic logic [DIV_W-1:0] reload_val(input logic [DIV_W-1:0] v);
    return (v <= DIV_W'(1)) ? '0 : v - DIV_W'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= reload_val(load_val_i);
    else if (cnt_q == '0)     cnt_q <= reload_val(div_i);
    else                      cnt_q <= cnt_q - DIV_W'(1);
  end

  assign tick_o = (cnt_q == '0);

  assert_cnt_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= reload_val(div_i));
  assert_reload_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && load_val_i > DIV_W'(1)) |=> !tick_o);
endmodule

// File: rtl/dbn_pin_filter.sv
module dbn_pin_filter #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic en_i,
  input  logic tick_i,
  output logic pin_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   sync_w;
  logic                   cand_q, out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
  end
  assign sync_w = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cand_q <= 1'b0;
      out_q  <= 1'b0;
    end else if (!en_i) begin
      // track input so enabling causes no step
      cand_q <= sync_w;
      out_q  <= sync_w;
    end else if (tick_i) begin
      cand_q <= sync_w;
      if (sync_w == cand_q) out_q <= sync_w;
    end
  end

  assign pin_o = en_i ? out_q : sync_w;

  assert_hold_no_tick_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_i) |=> $stable(out_q));
  assert_hold_disagree_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i && (sync_w != cand_q)) |=> $stable(out_q));
  assert_enable_seamless_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !$past(en_i)) |-> (pin_o == $past(pin_o)));
endmodule

// File: rtl/gpio_debounce_top.sv
module gpio_debounce_top
  import gpio_debounce_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 8,
  parameter int unsigned DIV_W       = 24,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic [7:0]          cfg_addr_i,
  input  logic [31:0]         cfg_wdata_i,
  output logic [31:0]         cfg_rdata_o,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] pin_o,
  output logic                tick_o
);
  logic [NUM_PINS-1:0] en_w;
  logic [DIV_W-1:0]    div_w, load_val_w;
  logic                load_w, tick_w;

  dbn_regs #(.NUM_PINS(NUM_PINS), .DIV_W(DIV_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(cfg_we_i), .addr_i(cfg_addr_i),
    .wdata_i(cfg_wdata_i), .rdata_o(cfg_rdata_o), .en_o(en_w), .div_o(div_w),
    .load_o(load_w), .load_val_o(load_val_w)
  );

  dbn_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk_i(clk_i), .rst_ni(rst_ni), .div_i(div_w), .load_i(load_w),
    .load_val_i(load_val_w), .tick_o(tick_w)
  );

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    dbn_pin_filter #(.SYNC_STAGES(SYNC_STAGES)) u_filt (
      .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(pin_i[g]), .en_i(en_w[g]),
      .tick_i(tick_w), .pin_o(pin_o[g])
    );
  end

  assign tick_o = tick_w;

  assert_reset_quiet_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (pin_o == '0 && tick_o));
endmodule

// File: tb/gpio_debounce_top_tb_top.sv
module gpio_debounce_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [7:0]  cfg_addr_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic [31:0] cfg_rdata_o;
  logic [NP-1:0] pin_i = '0;
  logic [NP-1:0] pin_o;
  logic        tick_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  gpio_debounce_top #(.NUM_PINS(NP), .DIV_W(24), .SYNC_STAGES(2)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i),
    .cfg_wdata_i(cfg_wdata_i), .cfg_rdata_o(cfg_rdata_o), .pin_i(pin_i),
    .pin_o(pin_o), .tick_o(tick_o)
  );

  // enable mask 0xF0, divisor 4: upper nibble filtered, lower raw
  localparam int NV = 6;
  localparam logic [NP-1:0] VEC_PIN  [NV] = '{8'hFF, 8'h00, 8'hFF, 8'h5A, 8'hA5, 8'h5A};
  localparam int            VEC_HOLD [NV] = '{12,    3,     12,    12,    2,     12};
  localparam logic [NP-1:0] VEC_EXP  [NV] = '{8'hFF, 8'hF0, 8'hFF, 8'h5A, 8'h55, 8'h5A};

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0; cfg_addr_i = '0; cfg_wdata_i = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    cfg_addr_i = a;
    #1 d = cfg_rdata_o;
    cfg_addr_i = '0;
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    int ticks;
    cyc(3);
    // R1 reset state
    check("R1 pin_o", 32'(pin_o), 0);
    check("R1 tick", 32'(tick_o), 1);
    rst_ni = 1'b1;
    cyc(1);
    rd(8'h40, r); check("R1 enable", r, 0);
    rd(8'h44, r); check("R1 divisor", r, 0);
    check("R1 tick after reset", 32'(tick_o), 1);

    // R2 field masking and ignored addresses
    wr(8'h44, 32'hFFFF_FFFF);
    rd(8'h44, r); check("R2 divisor mask", r, 32'h00FF_FFFF);
    wr(8'h40, 32'hFFFF_FFFF);
    rd(8'h40, r); check("R2 enable mask", r, 32'h0000_00FF);
    wr(8'h48, 32'h0);
    wr(8'h00, 32'h0);
    rd(8'h40, r); check("R2 ignore en", r, 32'h0000_00FF);
    rd(8'h44, r); check("R2 ignore div", r, 32'h00FF_FFFF);
    rd(8'h48, r); check("R2 unmapped read", r, 0);

    // R3 period with D=5
    wr(8'h44, 5);
    ticks = 0;
    for (int i = 0; i < 50; i++) begin
      if (i > 0) @(negedge clk_i);
      if (tick_o) ticks++;
    end
    check("R3 ticks D=5", ticks, 10);
    // R3 divisor 1 and 0
    wr(8'h44, 1);
    ticks = 0;
    for (int i = 0; i < 5; i++) begin if (tick_o) ticks++; @(negedge clk_i); end
    check("R3 ticks D=1", ticks, 5);
    wr(8'h44, 0);
    ticks = 0;
    for (int i = 0; i < 5; i++) begin if (tick_o) ticks++; @(negedge clk_i); end
    check("R3 ticks D=0", ticks, 5);

    // R4 immediate reload
    wr(8'h44, 100);
    cyc(7);
    wr(8'h44, 3);
    check("R4 cycle1", 32'(tick_o), 0);
    cyc(1); check("R4 cycle2", 32'(tick_o), 0);
    cyc(1); check("R4 cycle3", 32'(tick_o), 1);

    // R5/R6/R7 vector table
    wr(8'h40, 32'h0000_00F0);
    wr(8'h44, 4);
    pin_i = '0;
    cyc(12);
    check("R5 settle", 32'(pin_o), 0);
    for (int v = 0; v < NV; v++) begin
      pin_i = VEC_PIN[v];
      cyc(VEC_HOLD[v]);
      check((v == 1 || v == 4) ? "R6 glitch" : "R5 stable", 32'(pin_o), 32'(VEC_EXP[v]));
    end

    // R7 raw latency on disabled lower pins
    pin_i = 8'h5F;
    cyc(1); check("R7 one edge", 32'(pin_o[3:0]), 32'hA);
    cyc(1); check("R7 two edges", 32'(pin_o[3:0]), 32'hF);

    // R8 seamless enable
    wr(8'h44, 1000);
    wr(8'h40, 0);
    pin_i = 8'hFF;
    cyc(4);
    check("R8 before enable", 32'(pin_o), 32'hFF);
    wr(8'h40, 32'hFF);
    check("R8 at enable", 32'(pin_o), 32'hFF);
    pin_i = 8'h00;
    cyc(5);
    check("R8 filter engaged", 32'(pin_o), 32'hFF);

    // R1 reset mid-run
    rst_ni = 1'b0;
    cyc(1);
    check("R1 mid-run pin_o", 32'(pin_o), 0);
    rst_ni = 1'b1;
    cyc(1);
    rd(8'h40, r); check("R1 mid-run enable", r, 0);
    rd(8'h44, r); check("R1 mid-run divisor", r, 0);

    finish_run();
  end
endmodule